// File: doc/BRIEF.md
# NAND Raw Bus Cycle Engine

This block converts single host word accesses into raw NAND flash bus cycles. It is meant for direct, low-level control of the flash, where software places each command byte, address byte or data word on the bus itself. The host address says whether the access belongs to the engine, which kind of cycle to run, and which bank's chip enable to drive. The engine sequences chip enable, the latch enables, the write and read strobes and the data bus. The length of every phase comes from cycle counts supplied on configuration inputs.

Every access has the same sequence. First comes an optional turnaround gap, chosen from the previous and current cycle kinds. Then chip enable is asserted for a setup time, the strobe goes low, and the strobe goes high. Last, a one-cycle ready pulse returns read data. The data bus is 8 or 16 bits wide. In 16-bit mode the two bytes of a bus word sit in word bits 7:0 and 23:16.

Top module: `nand_cycle_engine`

## Requirements
- R1: An access is taken only when `host_addr[27:26]` is 2'b11 and `host_addr[1:0]` is 0 (command), 1 (address) or 2 (data). Any other request is ignored: no chip enable, no strobe and no ready.
- R2: `host_addr[25:24]` picks the bank. During an access exactly bit `bank` of `chip_en_n` is low. All bits are high when idle.
- R3: `lat_cmd` is high only in command cycles and `lat_adr` only in address cycles. Both are low in data cycles. Command and address cycles always write: they ignore `host_we`, drive `host_wdata[7:0]` on `bus_out[7:0]`, and drive `bus_out[15:8]` as zero.
- R4: With `wide_bus`=0, a data write drives `{8'h00, host_wdata[7:0]}`. A data read returns `{24'h0, bus_in[7:0]}`.
- R5: With `wide_bus`=1, a data write drives `{host_wdata[23:16], host_wdata[7:0]}`. A data read returns `{8'h0, bus_in[15:8], 8'h0, bus_in[7:0]}`.
- R6: The strobe stays low for `t_low` cycles and then high for `t_high` cycles. A count of 0 counts as 1 for every timing input.
- R7: Read data is captured at the `t_acc`-th rising edge after RE# falls. If that edge comes after low plus high time, the high phase is stretched until the capture.
- R8: Chip enable, the latch enables and the write data appear `t_cs` cycles before the strobe falls. A strobe is never low without a chip enable.
- R9: Before chip enable, the engine idles for a gap set by the last completed access (P) and the current one (C):
  - P read, C write-type: `t_rd_wr`.
  - P read, C read: `t_rd_rd`.
  - P address, C data: `t_adr_dat`.
  - P command, C read: `t_wr_rd`.
  - Otherwise there is no gap.
- R10: `host_ready` is a one-cycle pulse in the cycle after the high phase. In that cycle chip enable is released and both strobes are high.
- R11: After reset every chip enable and strobe is high, the latch enables, `bus_oe` and `host_ready` are low, and there is no previous access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_req | input | 1 | Access request, held until ready |
| host_we | input | 1 | 1 for write, 0 for read (data cycles only) |
| host_addr | input | 28 | Map select, bank, cycle type |
| host_wdata | input | 32 | Write word |
| host_ready | output | 1 | Access completion pulse |
| host_rdata | output | 32 | Read word, valid with ready |
| wide_bus | input | 1 | 1 selects 16-bit device bus |
| t_low | input | TW | Strobe low cycles |
| t_high | input | TW | Strobe high cycles |
| t_acc | input | TW | RE fall to capture cycles |
| t_cs | input | TW | Chip-enable setup cycles |
| t_rd_wr | input | TW | Read to write-type gap |
| t_rd_rd | input | TW | Read to read gap |
| t_wr_rd | input | TW | Command to read gap |
| t_adr_dat | input | TW | Address to data gap |
| chip_en_n | output | 4 | Per-bank chip enable, active low |
| lat_cmd | output | 1 | Command latch enable |
| lat_adr | output | 1 | Address latch enable |
| wr_n | output | 1 | Write strobe, active low |
| rd_n | output | 1 | Read strobe, active low |
| bus_out | output | 16 | Data bus output value |
| bus_oe | output | 1 | Data bus output enable |
| bus_in | input | 16 | Data bus input value |

## Verification
The assertions assume the host holds `host_req` and its address steady until `host_ready`, and drops it in the ready cycle. They also assume the timing inputs do not change during an access. The stimulus follows both rules: each access task sets the timing inputs only while the engine is idle, and it releases the request at the sampling point where ready is seen. Read data on `bus_in` changes once per cycle to a value that encodes the cycle index, so the captured word shows exactly which edge sampled it.

// File: rtl/nand_cycle_engine.sv
module nand_cycle_engine #(
  parameter int TW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          host_req,
  input  logic          host_we,
  input  logic [27:0]   host_addr,
  input  logic [31:0]   host_wdata,
  output logic          host_ready,
  output logic [31:0]   host_rdata,
  input  logic          wide_bus,
  input  logic [TW-1:0] t_low,
  input  logic [TW-1:0] t_high,
  input  logic [TW-1:0] t_acc,
  input  logic [TW-1:0] t_cs,
  input  logic [TW-1:0] t_rd_wr,
  input  logic [TW-1:0] t_rd_rd,
  input  logic [TW-1:0] t_wr_rd,
  input  logic [TW-1:0] t_adr_dat,
  output logic [3:0]    chip_en_n,
  output logic          lat_cmd,
  output logic          lat_adr,
  output logic          wr_n,
  output logic          rd_n,
  output logic [15:0]   bus_out,
  output logic          bus_oe,
  input  logic [15:0]   bus_in
);

  typedef enum logic [2:0] {S_IDLE, S_GAP, S_SETUP, S_LOW, S_HIGH, S_DONE} st_t;
  localparam logic [2:0] K_NONE = 3'd0, K_CMD = 3'd1, K_ADR = 3'd2, K_DWR = 3'd3, K_DRD = 3'd4;

  function automatic logic [TW-1:0] eff(input logic [TW-1:0] n);
    return (n == '0) ? TW'(1) : n;
  endfunction

  st_t           st;
  logic [2:0]    kind, last;
  logic [1:0]    bank;
  logic [15:0]   wd;
  logic [TW-1:0] cnt, rcnt, gap_len;
  logic          got;

  logic          hit, need_gap, is_rd, acc_hit;
  logic [2:0]    nkind;
  logic [TW-1:0] gsel;
  logic [15:0]   nwd;

  assign hit = host_req && host_addr[27:26] == 2'b11 && host_addr[1:0] != 2'b11;

  always_comb begin
    case (host_addr[1:0])
      2'd0:    nkind = K_CMD;
      2'd1:    nkind = K_ADR;
      default: nkind = host_we ? K_DWR : K_DRD;
    endcase
    if (nkind == K_DWR && wide_bus) nwd = {host_wdata[23:16], host_wdata[7:0]};
    else                            nwd = {8'h00, host_wdata[7:0]};
    need_gap = 1'b1;
    gsel     = '0;
    if (last == K_DRD && nkind != K_DRD)                   gsel = t_rd_wr;
    else if (last == K_DRD && nkind == K_DRD)              gsel = t_rd_rd;
    else if (last == K_ADR && (nkind == K_DWR || nkind == K_DRD)) gsel = t_adr_dat;
    else if (last == K_CMD && nkind == K_DRD)              gsel = t_wr_rd;
    else                                                   need_gap = 1'b0;
  end

  assign is_rd   = kind == K_DRD;
  assign acc_hit = is_rd && !got && rcnt == eff(t_acc);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; kind <= K_NONE; last <= K_NONE; bank <= '0; wd <= '0;
      cnt <= '0; rcnt <= '0; gap_len <= '0; got <= 1'b0; host_rdata <= '0;
    end else begin
      case (st)
        S_IDLE: if (hit) begin
          kind <= nkind; bank <= host_addr[25:24]; wd <= nwd;
          host_rdata <= '0; cnt <= TW'(1); gap_len <= eff(gsel);
          st <= need_gap ? S_GAP : S_SETUP;
        end
        S_GAP:
          if (cnt >= gap_len) begin st <= S_SETUP; cnt <= TW'(1); end
          else cnt <= cnt + 1'b1;
        S_SETUP:
          if (cnt >= eff(t_cs)) begin
            st <= S_LOW; cnt <= TW'(1); rcnt <= TW'(1); got <= 1'b0;
          end else cnt <= cnt + 1'b1;
        S_LOW, S_HIGH: begin
          rcnt <= rcnt + 1'b1;
          if (acc_hit) begin
            got <= 1'b1;
            host_rdata <= wide_bus ? {8'h00, bus_in[15:8], 8'h00, bus_in[7:0]}
                                   : {24'h0, bus_in[7:0]};
          end
          if (st == S_LOW) begin
            if (cnt >= eff(t_low)) begin st <= S_HIGH; cnt <= TW'(1); end
            else cnt <= cnt + 1'b1;
          end else if (cnt >= eff(t_high)) begin
            if (!is_rd || got || acc_hit) st <= S_DONE;
          end else cnt <= cnt + 1'b1;
        end
        S_DONE: begin last <= kind; st <= S_IDLE; end
        default: st <= S_IDLE;
      endcase
    end
  end

  logic active;
  assign active     = st == S_SETUP || st == S_LOW || st == S_HIGH;
  assign chip_en_n  = active ? ~(4'b0001 << bank) : 4'hF;
  assign lat_cmd    = active && kind == K_CMD;
  assign lat_adr    = active && kind == K_ADR;
  assign wr_n       = !(st == S_LOW && !is_rd);
  assign rd_n       = !(st == S_LOW && is_rd);
  assign bus_oe     = active && !is_rd;
  assign bus_out    = bus_oe ? wd : 16'h0000;
  assign host_ready = st == S_DONE;

endmodule

// File: rtl/nand_cycle_engine_chk.sv
module nand_cycle_engine_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [3:0] chip_en_n,
  input logic       lat_cmd,
  input logic       lat_adr,
  input logic       wr_n,
  input logic       rd_n,
  input logic       bus_oe,
  input logic       host_ready
);
  AST_ONE_BANK: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(~chip_en_n) <= 1); // R2
  AST_LATCH_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(lat_cmd && lat_adr)); // R3
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(!wr_n && !rd_n)); // R6
  AST_STROBE_HAS_CE: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_n || !rd_n) |-> chip_en_n != 4'hF); // R8
  AST_NO_DRIVE_READ: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_n |-> !bus_oe); // R4
  AST_READY_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    host_ready |=> !host_ready); // R10
  AST_READY_IDLE_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    host_ready |-> (wr_n && rd_n && chip_en_n == 4'hF)); // R10
endmodule

bind nand_cycle_engine nand_cycle_engine_chk u_chk (
  .clk(clk), .rst_n(rst_n), .chip_en_n(chip_en_n), .lat_cmd(lat_cmd),
  .lat_adr(lat_adr), .wr_n(wr_n), .rd_n(rd_n), .bus_oe(bus_oe),
  .host_ready(host_ready)
);

// File: tb/tb_nand_cycle_engine.sv
module tb_nand_cycle_engine;
  localparam int CLK_NS = 10;
  localparam int TW = 6;

  logic clk = 0, rst_n = 0;
  logic host_req = 0, host_we = 0, host_ready, wide_bus = 0;
  logic [27:0] host_addr = '0;
  logic [31:0] host_wdata = '0, host_rdata;
  logic [TW-1:0] t_low = 1, t_high = 1, t_acc = 1, t_cs = 1;
  logic [TW-1:0] t_rd_wr = 0, t_rd_rd = 0, t_wr_rd = 0, t_adr_dat = 0;
  logic [3:0] chip_en_n;
  logic lat_cmd, lat_adr, wr_n, rd_n, bus_oe;
  logic [15:0] bus_out, bus_in = '0;

  nand_cycle_engine #(.TW(TW)) dut (.*);

  always #(CLK_NS/2) clk = ~clk;

  int nchk = 0, nerr = 0;
  int m_ce, m_fall, m_rise, m_rdy;
  logic [3:0] m_mask;
  logic m_cle, m_ale, m_oe;
  logic [15:0] m_dq;
  logic [31:0] m_rdata;
  int bprev = 0; // 0 none 1 cmd 2 adr 3 wr 4 rd

  task automatic check(input string r, input longint act, input longint exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", r, act, exp);
    end
  endtask

  function automatic int e(input logic [TW-1:0] n);
    return (n == 0) ? 1 : int'(n);
  endfunction

  function automatic int exp_gap(input int p, input int c);
    if (p == 4 && c != 4) return e(t_rd_wr);
    if (p == 4 && c == 4) return e(t_rd_rd);
    if (p == 2 && (c == 3 || c == 4)) return e(t_adr_dat);
    if (p == 1 && c == 4) return e(t_wr_rd);
    return 0;
  endfunction

  function automatic logic [15:0] pat(input int k);
    logic [7:0] b;
    b = k[7:0];
    return {b ^ 8'h5A, b};
  endfunction

  function automatic logic [27:0] mk(input int bank, input int ty);
    return {2'b11, bank[1:0], 22'h0, ty[1:0]};
  endfunction

  task automatic xfer(input logic [27:0] a, input logic w, input logic [31:0] d);
    @(negedge clk);
    host_addr = a; host_we = w; host_wdata = d; host_req = 1; bus_in = pat(0);
    m_ce = -1; m_fall = -1; m_rise = -1; m_rdy = -1; m_mask = 4'hF;
    for (int k = 1; k < 300; k++) begin
      @(negedge clk);
      if (chip_en_n != 4'hF && m_ce < 0) begin m_ce = k; m_mask = chip_en_n; end
      if ((!wr_n || !rd_n) && m_fall < 0) begin
        m_fall = k; m_cle = lat_cmd; m_ale = lat_adr; m_dq = bus_out; m_oe = bus_oe;
      end
      if (m_fall >= 0 && m_rise < 0 && wr_n && rd_n) m_rise = k;
      if (host_ready) begin m_rdy = k; m_rdata = host_rdata; host_req = 0; break; end
      bus_in = pat(k);
    end
    host_req = 0;
  endtask

  // cur: 1 cmd 2 adr 3 wr 4 rd
  task automatic timing_chk(input string r, input int cur);
    int g;
    g = exp_gap(bprev, cur);
    check({r, " gap"}, m_ce - 1, g);
    check({r, " setup"}, m_fall - m_ce, e(t_cs));
    check({r, " low"}, m_rise - m_fall, e(t_low));
    bprev = cur;
  endtask

  task automatic t_reset();
    check("R11 ce", chip_en_n, 4'hF);
    check("R11 strobes", {wr_n, rd_n}, 2'b11);
    check("R11 latches", {lat_cmd, lat_adr, bus_oe, host_ready}, 0);
  endtask

  task automatic t_cmd();
    t_cs = 2; t_low = 3; t_high = 2;
    xfer(mk(1, 0), 1'b0, 32'h1234_56A7);
    timing_chk("R8 R6 cmd", 1);
    check("R6 high", m_rdy - m_rise, 2);
    check("R2 bank1", m_mask, 4'b1101);
    check("R3 cmd latches", {m_cle, m_ale}, 2'b10);
    check("R3 cmd data", m_dq, 16'h00A7);
    check("R3 cmd drives", m_oe, 1);
    check("R10 ready", m_rdy, 1 + 2 + 3 + 2);
  endtask

  task automatic t_adr_then_write();
    t_adr_dat = 3;
    xfer(mk(2, 1), 1'b1, 32'hFFFF_FF3C);
    timing_chk("R9 adr", 2);
    check("R2 bank2", m_mask, 4'b1011);
    check("R3 adr latches", {m_cle, m_ale}, 2'b01);
    check("R3 adr data", m_dq, 16'h003C);
    xfer(mk(3, 2), 1'b1, 32'h00AB_00C5);
    timing_chk("R9 adr->data", 3);
    check("R2 bank3", m_mask, 4'b0111);
    check("R4 wr latches", {m_cle, m_ale}, 2'b00);
    check("R4 wr data", m_dq, 16'h00C5);
  endtask

  task automatic t_reads();
    int cap;
    t_wr_rd = 4; t_rd_rd = 2; t_rd_wr = 5; t_cs = 1; t_acc = 2; t_low = 3; t_high = 1;
    xfer(mk(0, 0), 1'b1, 32'h70);
    timing_chk("R3 cmd", 1);
    xfer(mk(0, 2), 1'b0, 32'hFFFF_FFFF);
    timing_chk("R9 cmd->rd", 4);
    cap = m_ce + e(t_cs) + e(t_acc) - 1;
    check("R7 rd capture", m_rdata, {24'h0, pat(cap)[7:0]});
    check("R4 rd no drive", m_oe, 0);
    xfer(mk(0, 2), 1'b0, 32'h0);
    timing_chk("R9 rd->rd", 4);
    xfer(mk(0, 2), 1'b1, 32'h11);
    timing_chk("R9 rd->wr", 3);
    check("R4 wr rdata zero", m_rdata, 0);
  endtask

  task automatic t_wide();
    int cap;
    wide_bus = 1;
    xfer(mk(1, 2), 1'b1, 32'hDEAD_BEEF);
    timing_chk("R5 wr", 3);
    check("R5 wide write", m_dq, 16'hADEF);
    xfer(mk(0, 0), 1'b1, 32'h00AB_0005);
    timing_chk("R5 cmd", 1);
    check("R3 cmd narrow in wide", m_dq, 16'h0005);
    xfer(mk(1, 2), 1'b0, 32'h0);
    timing_chk("R5 rd", 4);
    cap = m_ce + e(t_cs) + e(t_acc) - 1;
    check("R5 wide read", m_rdata, {8'h0, pat(cap)[15:8], 8'h0, pat(cap)[7:0]});
    wide_bus = 0;
  endtask

  task automatic t_zero();
    t_low = 0; t_high = 0; t_cs = 0; t_acc = 0; t_rd_wr = 0;
    xfer(mk(2, 2), 1'b1, 32'h55);
    timing_chk("R6 zero", 3);
    check("R6 zero high", m_rdy - m_rise, 1);
  endtask

  task automatic t_stretch();
    int cap;
    t_low = 1; t_high = 1; t_cs = 1; t_acc = 6;
    xfer(mk(0, 2), 1'b0, 32'h0);
    timing_chk("R7 stretch", 4);
    check("R7 stretch total", m_rdy - m_fall, 6);
    cap = m_ce + e(t_cs) + 6 - 1;
    check("R7 stretch capture", m_rdata, {24'h0, pat(cap)[7:0]});
  endtask

  task automatic t_ignored(input logic [27:0] a, input string r);
    int seen = 0;
    @(negedge clk);
    host_addr = a; host_we = 1; host_req = 1;
    for (int k = 0; k < 12; k++) begin
      @(negedge clk);
      if (chip_en_n != 4'hF || !wr_n || !rd_n || host_ready) seen++;
    end
    host_req = 0;
    check(r, seen, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_cmd();
    t_adr_then_write();
    t_reads();
    t_wide();
    t_zero();
    t_stretch();
    t_ignored({2'b10, 2'd1, 22'h0, 2'd0}, "R1 other map");
    t_ignored({2'b11, 2'd1, 22'h0, 2'd3}, "R1 type 3");
    xfer(mk(1, 1), 1'b1, 32'h9);
    timing_chk("R1 history kept", 2);
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    #(CLK_NS * 150000);
    nerr++;
    nchk++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule